// File: doc/BRIEF.md
# Card Slot Presence and Interrupt Conditioner

This block sits between a removable memory-card slot and the host side of a card controller. It decides whether a card is in the slot, using up to two detect sources: the card's DATA3 line and a separate detect pin. The separate pin has a selectable polarity. Both inputs are synchronised and combined, then optionally debounced, and the result appears as one presence output. Each change of the debounced presence sets a sticky flag. Software clears the flag by writing a one to it.

The block can also take over the DATA3 pad and drive it as a plain output at a programmed level. The controller's raw interrupt request becomes a host IRQ line. That line either follows the request as a level or emits a fixed-width pulse on each new request. The active polarity of each IRQ mode is programmed separately.

Two 8-bit control registers and a clear strobe for the flag are reached through a write-only register port. The port address selects the target: 0 is the detect control register (called CTLA below), 1 is the interrupt and filter control register (called CTLB below), and 2 is the flag clear.

Top module: `slot_detect_irq`

## Requirements
- R1: After reset both control registers hold 0x01. So DATA3 detection is on, the detect pin is off, the output override is off, debounce is on, and the IRQ is in active-high level mode. Presence, the change flag and `dat3_oe` all read 0.
- R2: CTLA bit 0 enables DATA3 as an active-high detect source. CTLA bit 1 enables the detect pin. Presence is the OR of the enabled, polarity-corrected sources, so it is 0 when neither source is enabled.
- R3: CTLA bit 2 sets the detect-pin polarity. At 0 a low pin means a card is present; at 1 a high pin means present.
- R4: With CTLA bit 4 set, `dat3_oe` is 1, `dat3_out` equals CTLA bit 5, and DATA3 no longer counts as a detect source. With bit 4 clear, `dat3_oe` and `dat3_out` are both 0.
- R5: With CTLB bit 0 clear, `card_present` follows the combined presence value SYNC_STAGES+1 clocks after an input edge.
- R6: With CTLB bit 0 set, `card_present` changes only after the combined value has differed from it for DB_TICKS consecutive prescaler ticks. One tick occurs every TICK_DIV clocks. A shorter disturbance leaves the output unchanged.
- R7: CTLB bit 1 at 0 selects level mode. In level mode, `irq_out` equals `irq_req` one clock later, inverted when CTLB bit 3 is 1.
- R8: CTLB bit 1 at 1 selects pulse mode. Each rising edge of `irq_req` gives a pulse PULSE_W clocks wide, starting one clock after the edge. CTLB bit 2 selects the pulse level: 1 means high pulses, 0 means low pulses. Between pulses, `irq_out` rests at the opposite level.
- R9: Every change of `card_present` sets `present_chg_flag`. Writing data with bit 0 set to address 2 clears the flag. A write with bit 0 clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register select: 0 CTLA, 1 CTLB, 2 flag clear |
| cfg_wr_data | input | 8 | Register write data |
| dat3_in | input | 1 | DATA3 pad input |
| dat3_out | output | 1 | DATA3 pad output value |
| dat3_oe | output | 1 | DATA3 pad output enable |
| ext_det_in | input | 1 | Detect pin input |
| card_present | output | 1 | Conditioned card presence |
| present_chg_flag | output | 1 | Sticky presence-change flag |
| irq_req | input | 1 | Raw interrupt request from the card controller |
| irq_out | output | 1 | Conditioned host IRQ line |

## Verification
On every clock, the embedded properties check four things. Debounced presence holds while the raw value agrees with it or no tick occurs. The change flag is set by each presence change and held until a clear write. A pulse started in pulse mode lasts at least two clocks. These checks look at one step at a time. Only the bench's scenarios can show the end-to-end results: the full source, polarity and override truth table; the sixteen-tick acceptance time against a rejected short glitch; and the exact IRQ level or pulse shape for each polarity setting.

// File: rtl/scd_pkg.sv
package scd_pkg;

  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_DET_CTL  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_IRQ_CTL  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG_CLR = 2'd2;

  // detect control register fields
  localparam int unsigned DB_D3_EN    = 0;
  localparam int unsigned DB_EXT_EN   = 1;
  localparam int unsigned DB_EXT_HIGH = 2;
  localparam int unsigned DB_D3_OVR   = 4;
  localparam int unsigned DB_D3_VAL   = 5;

  // interrupt / filter control register fields
  localparam int unsigned IB_FILT_EN   = 0;
  localparam int unsigned IB_PULSE     = 1;
  localparam int unsigned IB_PULSE_HI  = 2;
  localparam int unsigned IB_LEVEL_LOW = 3;

  localparam int unsigned FB_CLR = 0;

  typedef struct packed {
    logic d3_det_en;
    logic ext_det_en;
    logic ext_pol_high;
    logic d3_ovr;
    logic d3_ovr_val;
  } det_cfg_t;

  typedef struct packed {
    logic filt_en;
    logic pulse_mode;
    logic pulse_pol_high;
    logic level_pol_low;
  } irq_cfg_t;

  // both registers come out of reset as 0x01
  localparam det_cfg_t DET_CFG_RST = '{d3_det_en: 1'b1, ext_det_en: 1'b0,
                                       ext_pol_high: 1'b0, d3_ovr: 1'b0,
                                       d3_ovr_val: 1'b0};
  localparam irq_cfg_t IRQ_CFG_RST = '{filt_en: 1'b1, pulse_mode: 1'b0,
                                       pulse_pol_high: 1'b0, level_pol_low: 1'b0};

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_n;

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        assign pipe_n[gs] = d_in;
      end else begin : g_next
        assign pipe_n[gs] = pipe_q[gs-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_n;
  end

  assign d_out = pipe_q[STAGES-1];

endmodule

// File: rtl/scd_cfg_regs.sv
module scd_cfg_regs
  import scd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [REG_DATA_W-1:0] wr_data,
  input  logic                  chg_in,
  output det_cfg_t              det_cfg,
  output irq_cfg_t              irq_cfg,
  output logic                  chg_flag
);

  det_cfg_t det_q, det_n;
  irq_cfg_t irq_q, irq_n;
  logic     flag_q, flag_n;
  logic     det_we, irq_we, clr_hit;
  logic     unused_wr_bits;

  assign det_we  = wr_en && (wr_addr == ADDR_DET_CTL);
  assign irq_we  = wr_en && (wr_addr == ADDR_IRQ_CTL);
  assign clr_hit = wr_en && (wr_addr == ADDR_FLAG_CLR) && wr_data[FB_CLR];

  assign unused_wr_bits = ^{wr_data[7:6], wr_data[3]};

  always_comb begin
    det_n = det_q;
    if (det_we) begin
      det_n.d3_det_en    = wr_data[DB_D3_EN];
      det_n.ext_det_en   = wr_data[DB_EXT_EN];
      det_n.ext_pol_high = wr_data[DB_EXT_HIGH];
      det_n.d3_ovr       = wr_data[DB_D3_OVR];
      det_n.d3_ovr_val   = wr_data[DB_D3_VAL];
    end
  end

  always_comb begin
    irq_n = irq_q;
    if (irq_we) begin
      irq_n.filt_en        = wr_data[IB_FILT_EN];
      irq_n.pulse_mode     = wr_data[IB_PULSE];
      irq_n.pulse_pol_high = wr_data[IB_PULSE_HI];
      irq_n.level_pol_low  = wr_data[IB_LEVEL_LOW];
    end
  end

  // a new change wins over a clear issued in the same cycle
  always_comb begin
    flag_n = flag_q;
    if (clr_hit) flag_n = 1'b0;
    if (chg_in)  flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q  <= DET_CFG_RST;
      irq_q  <= IRQ_CFG_RST;
      flag_q <= 1'b0;
    end else begin
      det_q  <= det_n;
      irq_q  <= irq_n;
      flag_q <= flag_n;
    end
  end

  assign det_cfg  = det_q;
  assign irq_cfg  = irq_q;
  assign chg_flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chg_in |=> chg_flag); // R9

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !clr_hit) |=> chg_flag); // R9

endmodule

// File: rtl/scd_debounce.sv
module scd_debounce #(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned DB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic raw_in,
  output logic present,
  output logic chg
);

  localparam int unsigned PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned ST_W = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [PS_W-1:0] PS_MAX = PS_W'(TICK_DIV - 1);
  localparam logic [ST_W-1:0] ST_MAX = ST_W'(DB_TICKS - 1);

  logic [PS_W-1:0] ps_q, ps_n;
  logic [ST_W-1:0] st_q, st_n;
  logic            pres_q, pres_n;
  logic            tick;

  assign tick = (ps_q == PS_MAX);

  always_comb begin
    ps_n = tick ? '0 : ps_q + 1'b1;
  end

  always_comb begin
    pres_n = pres_q;
    st_n   = st_q;
    if (!filt_en) begin
      pres_n = raw_in;
      st_n   = '0;
    end else if (raw_in == pres_q) begin
      st_n = '0;
    end else if (tick) begin
      if (st_q == ST_MAX) begin
        pres_n = raw_in;
        st_n   = '0;
      end else begin
        st_n = st_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      st_q   <= '0;
      pres_q <= 1'b0;
    end else begin
      ps_q   <= ps_n;
      st_q   <= st_n;
      pres_q <= pres_n;
    end
  end

  assign present = pres_q;
  assign chg     = (pres_n != pres_q);

  AST_DB_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && (raw_in == pres_q)) |=> $stable(pres_q)); // R6

  AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !tick) |=> $stable(pres_q)); // R6

endmodule

// File: rtl/scd_irq_shaper.sv
module scd_irq_shaper #(
  parameter int unsigned PULSE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic pulse_pol_high,
  input  logic level_pol_low,
  input  logic req,
  output logic irq
);

  localparam int unsigned CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W - 1);

  logic             req_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             on_q, on_n;
  logic             irq_q, irq_n;
  logic             start;

  assign start = pulse_mode && req && !req_d_q;

  always_comb begin
    if (start)             cnt_n = CNT_LOAD;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
    else                   cnt_n = '0;
    on_n = start || (cnt_q != '0);
    if (pulse_mode) irq_n = on_n ? pulse_pol_high : !pulse_pol_high;
    else            irq_n = req ^ level_pol_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      cnt_q   <= '0;
      on_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      req_d_q <= req;
      cnt_q   <= cnt_n;
      on_q    <= on_n;
      irq_q   <= irq_n;
    end
  end

  assign irq = irq_q;

  generate
    if (PULSE_W >= 2) begin : g_width_chk
      AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |=> on_q); // R8
    end
  endgenerate

endmodule

// File: rtl/slot_detect_irq.sv
module slot_detect_irq
  import scd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 1000,
  parameter int unsigned DB_TICKS    = 16,
  parameter int unsigned PULSE_W     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [1:0] cfg_wr_addr,
  input  logic [7:0] cfg_wr_data,
  input  logic       dat3_in,
  output logic       dat3_out,
  output logic       dat3_oe,
  input  logic       ext_det_in,
  output logic       card_present,
  output logic       present_chg_flag,
  input  logic       irq_req,
  output logic       irq_out
);

  det_cfg_t   det_cfg;
  irq_cfg_t   irq_cfg;
  logic [1:0] pad_raw, pad_s;
  logic       d3_term, ext_term, raw_present;
  logic       pres_chg;

  scd_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (cfg_wr_data),
    .chg_in   (pres_chg),
    .det_cfg  (det_cfg),
    .irq_cfg  (irq_cfg),
    .chg_flag (present_chg_flag)
  );

  assign pad_raw = {ext_det_in, dat3_in};

  scd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_raw),
    .d_out (pad_s)
  );

  // DATA3 counts only while the pad is not being driven by the block
  assign d3_term     = det_cfg.d3_det_en && !det_cfg.d3_ovr && pad_s[0];
  assign ext_term    = det_cfg.ext_det_en && (pad_s[1] ~^ det_cfg.ext_pol_high);
  assign raw_present = d3_term || ext_term;

  scd_debounce #(.TICK_DIV(TICK_DIV), .DB_TICKS(DB_TICKS)) u_db (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt_en (irq_cfg.filt_en),
    .raw_in  (raw_present),
    .present (card_present),
    .chg     (pres_chg)
  );

  scd_irq_shaper #(.PULSE_W(PULSE_W)) u_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .pulse_mode     (irq_cfg.pulse_mode),
    .pulse_pol_high (irq_cfg.pulse_pol_high),
    .level_pol_low  (irq_cfg.level_pol_low),
    .req            (irq_req),
    .irq            (irq_out)
  );

  assign dat3_oe  = det_cfg.d3_ovr;
  assign dat3_out = det_cfg.d3_ovr && det_cfg.d3_ovr_val;

endmodule

// File: tb/slot_detect_irq_tb.sv
module slot_detect_irq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_addr = '0;
  logic [7:0] cfg_wr_data = '0;
  logic       dat3_in = 1'b0;
  logic       ext_det_in = 1'b0;
  logic       irq_req = 1'b0;
  logic       dat3_out, dat3_oe, card_present, present_chg_flag, irq_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  slot_detect_irq #(.SYNC_STAGES(2), .TICK_DIV(4), .DB_TICKS(16), .PULSE_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .dat3_in(dat3_in), .dat3_out(dat3_out),
    .dat3_oe(dat3_oe), .ext_det_in(ext_det_in), .card_present(card_present),
    .present_chg_flag(present_chg_flag), .irq_req(irq_req), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    dat3_in = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk(card_present == 1'b0, "R1 present", card_present, 0);
    chk(present_chg_flag == 1'b0, "R1 flag", present_chg_flag, 0);
    chk(dat3_oe == 1'b0, "R1 oe", dat3_oe, 0);
    chk(irq_out == 1'b0, "R1 irq idle", irq_out, 0);
    irq_req = 1'b1; cyc(2);
    chk(irq_out == 1'b1, "R1 level active high", irq_out, 1);
    irq_req = 1'b0;
    cyc(40);
    chk(card_present == 1'b0, "R1 debounce on by default", card_present, 0);
    cyc(40);
    chk(card_present == 1'b1, "R1 DATA3 source on by default", card_present, 1);
    chk(present_chg_flag == 1'b1, "R9 flag set on change", present_chg_flag, 1);
    wr(2'd2, 8'h00);
    chk(present_chg_flag == 1'b1, "R9 zero write keeps flag", present_chg_flag, 1);
    wr(2'd2, 8'h01);
    chk(present_chg_flag == 1'b0, "R9 one write clears flag", present_chg_flag, 0);

    // R2 R3 R4 R5: unfiltered sweep over sources, polarity and override
    wr(2'd1, 8'h00);
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] a;
        logic exp_p;
        a = {2'b00, c[4], c[3], 1'b0, c[2], c[1], c[0]};
        wr(2'd0, a);
        dat3_in = p[0]; ext_det_in = p[1];
        cyc(5);
        exp_p = (a[0] & ~a[4] & p[0]) | (a[1] & (p[1] == a[2]));
        chk(card_present == exp_p, "R2 R3 R5 presence", card_present, exp_p);
        chk(dat3_oe == a[4], "R4 oe", dat3_oe, a[4]);
        chk(dat3_out == (a[4] & a[5]), "R4 out value", dat3_out, a[4] & a[5]);
      end
    end

    // R6: debounce acceptance time and glitch rejection
    wr(2'd0, 8'h02);
    ext_det_in = 1'b1;
    cyc(5);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    chk(card_present == 1'b0, "R6 start absent", card_present, 0);
    ext_det_in = 1'b0;
    cyc(50);
    chk(card_present == 1'b0, "R6 not yet accepted", card_present, 0);
    cyc(30);
    chk(card_present == 1'b1, "R6 accepted after 16 ticks", card_present, 1);
    wr(2'd2, 8'h01);
    ext_det_in = 1'b1; cyc(30); ext_det_in = 1'b0;
    cyc(200);
    chk(card_present == 1'b1, "R6 short glitch rejected", card_present, 1);
    chk(present_chg_flag == 1'b0, "R9 no change no flag", present_chg_flag, 0);

    // R7: level mode both polarities
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd1, pol[0] ? 8'h08 : 8'h00);
      for (int r = 0; r < 2; r++) begin
        irq_req = r[0]; cyc(2);
        chk(irq_out == (r[0] ^ pol[0]), "R7 level", irq_out, r[0] ^ pol[0]);
      end
      irq_req = 1'b0; cyc(2);
    end

    // R8: pulse mode both polarities
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd1, pol[0] ? 8'h06 : 8'h02);
      cyc(2);
      chk(irq_out == !pol[0], "R8 rest level", irq_out, !pol[0]);
      for (int k = 0; k < 2; k++) begin
        irq_req = 1'b1;
        cyc(1);
        chk(irq_out == pol[0], "R8 pulse cycle 1", irq_out, pol[0]);
        cyc(1);
        chk(irq_out == pol[0], "R8 pulse cycle 2", irq_out, pol[0]);
        cyc(1);
        chk(irq_out == !pol[0], "R8 pulse ended", irq_out, !pol[0]);
        cyc(4);
        chk(irq_out == !pol[0], "R8 held request no repeat", irq_out, !pol[0]);
        irq_req = 1'b0;
        cyc(3);
        chk(irq_out == !pol[0], "R8 fall no pulse", irq_out, !pol[0]);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule